// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block sits between a synchronous memory front end and its command and data paths. It takes care of putting the memory into a low-power sleep state and bringing it back out. An active-high sleep request arrives from outside without any timing relation to the clock. The block passes it through a two-flop synchronizer. Once the synchronized request is seen, the block asserts a sleeping flag. While that flag is high, every command is dropped, the read data output enable is forced low so the data pins float, and the address presented to the array is frozen. Nothing stored in the array and no front-end state is touched while asleep.

When the request drops, sleep ends. A recovery window of a fixed, parameterized number of cycles follows. Deselects and reads pass through normally during this window. Any write is turned into a deselect and reported on an error strobe. Stopping the clock is also an acceptable way to save power: the block's registers simply keep their values. Actual power switching happens elsewhere.

Commands use two bits. With `cmdSel`=0 the command is a deselect. With `cmdSel`=1 and `cmdWe`=0 it is a read. With `cmdSel`=1 and `cmdWe`=1 it is a write.

Top module: `mem_sleep_seq`

## Requirements
- R1: After reset, `sleeping` and `recovering` are 0. A request held low leaves the block in normal operation.
- R2: If `sleepReq` is sampled high at rising edge k, `sleeping` is 1 after edge k+1. It is still 0 after edge k unless an earlier request caused it.
- R3: While `sleeping` is 1, `memSel`, `memWe` and `wrBlockErr` are 0 whatever the command inputs are.
- R4: While `sleeping` is 1, `dataOe` is 0 and `dataOut` is all zeros, whatever `oeIn` and `rdDataIn` are.
- R5: While `sleeping` is 1, `memAddr` holds the `addrIn` value sampled at the last edge before sleep began. Outside sleep, `memAddr` equals `addrIn`.
- R6: `sleeping` falls two edges after `sleepReq` is first sampled low. From that same cycle, `recovering` is 1 for exactly REC_CYCLES cycles. `sleeping` and `recovering` are never 1 together.
- R7: While `recovering` is 1, deselects and reads pass unchanged: `memSel`=`cmdSel`, `memWe`=0, and read data is enabled by `oeIn`.
- R8: While `recovering` is 1, a write (`cmdSel`=1, `cmdWe`=1) gives `memSel`=0, `memWe`=0 and `wrBlockErr`=1.
- R9: In normal operation, `memSel`=`cmdSel` and `memWe`=`cmdSel`&`cmdWe`. `dataOe`=`oeIn`, `dataOut`=`rdDataIn` when `oeIn` is 1 (zero otherwise), and `wrBlockErr`=0.
- R10: If the synchronized request rises again during recovery, `recovering` clears in the same cycle that `sleeping` rises.
- R11: A request sampled high at only one edge gives exactly one cycle of `sleeping`, followed by a full recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Asynchronous active-high sleep request |
| cmdSel | input | 1 | Command select (0 = deselect) |
| cmdWe | input | 1 | Write qualifier of a selected command |
| addrIn | input | ADDR_W | Command address |
| oeIn | input | 1 | Read data output enable request |
| rdDataIn | input | DATA_W | Read data from the array |
| memSel | output | 1 | Filtered select to the array |
| memWe | output | 1 | Filtered write enable to the array |
| memAddr | output | ADDR_W | Address to the array, frozen during sleep |
| dataOe | output | 1 | Data pin drive enable (0 = high impedance) |
| dataOut | output | DATA_W | Read data toward the pins |
| wrBlockErr | output | 1 | Write refused during recovery |
| sleeping | output | 1 | Sleep state flag |
| recovering | output | 1 | Recovery window flag |

## Verification
A wrong synchronizer depth moves the `sleeping` edge by a whole cycle. The bench catches this in the first cycle of every entry and exit. A recovery counter that loads or clears wrongly shows up as a `recovering` window of the wrong length, or as writes that get through or are refused at the wrong time. This is visible within REC_CYCLES cycles of the wake-up. A bad address hold appears on `memAddr` in the first sleeping cycle in which `addrIn` changes. Random commands, including frequent writes, run alongside long sleeps, one-cycle pulses and re-requests during recovery, and every output is compared against a reference model on every cycle.

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;
  // Strobes from the sequencing control to the datapath gating
  typedef struct packed {
    logic blockAll;    // sleep: drop commands, float data, freeze address
    logic blockWrite;  // recovery: convert writes to deselects
  } slpStrobeT;
endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import mem_sleep_pkg::*;
#(
  parameter int REC_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  output slpStrobeT strobe,
  output logic      sleeping,
  output logic      recovering
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REC_CYCLES);

  logic syncFirst;
  logic syncSecond;
  logic [CNT_W-1:0] recCnt;

  // Two-flop synchronizer; the second stage is the sleep state (R2, R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncFirst  <= 1'b0;
      syncSecond <= 1'b0;
    end else begin
      syncFirst  <= sleepReq;
      syncSecond <= syncFirst;
    end
  end

  // Recovery counter: loaded on wake, cleared on re-entry (R6, R10, R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (syncFirst) begin
      recCnt <= '0;
    end else if (syncSecond) begin
      recCnt <= CNT_LOAD;
    end else if (recCnt != '0) begin
      recCnt <= recCnt - 1'b1;
    end
  end

  always_comb begin
    sleeping          = syncSecond;
    recovering        = (recCnt != '0);
    strobe.blockAll   = syncSecond;
    strobe.blockWrite = (recCnt != '0);
  end
endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import mem_sleep_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slpStrobeT         strobe,
  input  logic              cmdSel,
  input  logic              cmdWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              oeIn,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic              memSel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              wrBlockErr
);
  logic [ADDR_W-1:0] addrHold;
  logic              isWrite;

  // Address captured while awake; frozen during sleep (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
    end else if (!strobe.blockAll) begin
      addrHold <= addrIn;
    end
  end

  always_comb begin
    isWrite    = cmdSel && cmdWe;
    // R3 sleep drops everything; R8 recovery drops writes
    memSel     = cmdSel && !strobe.blockAll && !(strobe.blockWrite && isWrite);
    memWe      = memSel && cmdWe;
    wrBlockErr = isWrite && strobe.blockWrite && !strobe.blockAll;
    memAddr    = strobe.blockAll ? addrHold : addrIn;
    // R4 data pins float while asleep
    dataOe     = oeIn && !strobe.blockAll;
    dataOut    = dataOe ? rdDataIn : '0;
  end
endmodule

// File: rtl/mem_sleep_seq.sv
module mem_sleep_seq
  import mem_sleep_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int REC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic              cmdSel,
  input  logic              cmdWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              oeIn,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic              memSel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              dataOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              wrBlockErr,
  output logic              sleeping,
  output logic              recovering
);
  slpStrobeT strobe;

  slp_ctrl #(.REC_CYCLES(REC_CYCLES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .strobe     (strobe),
    .sleeping   (sleeping),
    .recovering (recovering)
  );

  slp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdSel     (cmdSel),
    .cmdWe      (cmdWe),
    .addrIn     (addrIn),
    .oeIn       (oeIn),
    .rdDataIn   (rdDataIn),
    .memSel     (memSel),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .dataOe     (dataOe),
    .dataOut    (dataOut),
    .wrBlockErr (wrBlockErr)
  );
endmodule

// File: rtl/mem_sleep_seq_chk.sv
module mem_sleep_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepReq,
  input logic              sleeping,
  input logic              recovering,
  input logic              memSel,
  input logic              memWe,
  input logic              wrBlockErr,
  input logic              dataOe,
  input logic [ADDR_W-1:0] memAddr
);
  p_entry_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleeping) |-> $past(sleepReq, 2));

  p_quiet_sleep_r3: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> (!memSel && !memWe && !wrBlockErr));

  p_float_sleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> !dataOe);

  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && $past(sleeping)) |-> $stable(memAddr));

  p_wake_recover_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleeping) |-> recovering);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(sleeping && recovering));

  p_no_write_rec_r8: assert property (@(posedge clk) disable iff (!rstN)
    recovering |-> !memWe);
endmodule

bind mem_sleep_seq mem_sleep_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sleepReq   (sleepReq),
  .sleeping   (sleeping),
  .recovering (recovering),
  .memSel     (memSel),
  .memWe      (memWe),
  .wrBlockErr (wrBlockErr),
  .dataOe     (dataOe),
  .memAddr    (memAddr)
);

// File: tb/mem_sleep_seq_tb_top.sv
module mem_sleep_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam int REC_CYCLES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic cmdSel = 1'b0;
  logic cmdWe = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic oeIn = 1'b0;
  logic [DATA_W-1:0] rdDataIn = '0;
  logic memSel, memWe, dataOe, wrBlockErr, sleeping, recovering;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] dataOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int writeMix = 50;

  mem_sleep_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYCLES(REC_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .cmdSel(cmdSel), .cmdWe(cmdWe),
    .addrIn(addrIn), .oeIn(oeIn), .rdDataIn(rdDataIn), .memSel(memSel),
    .memWe(memWe), .memAddr(memAddr), .dataOe(dataOe), .dataOut(dataOut),
    .wrBlockErr(wrBlockErr), .sleeping(sleeping), .recovering(recovering)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: request history and a recovery countdown
  bit reqHist[$];
  bit mSleep = 0;
  int mRecLeft = 0;
  logic [ADDR_W-1:0] mHold = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqHist.delete();
      mSleep = 0;
      mRecLeft = 0;
      mHold = '0;
    end else begin
      bit nextSleep;
      if (!mSleep) mHold = addrIn;
      reqHist.push_back(sleepReq);
      nextSleep = (reqHist.size() >= 2) ? reqHist[reqHist.size()-2] : 1'b0;
      if (nextSleep) mRecLeft = 0;
      else if (mSleep) mRecLeft = REC_CYCLES;
      else if (mRecLeft > 0) mRecLeft = mRecLeft - 1;
      mSleep = nextSleep;
      if (reqHist.size() > 4) void'(reqHist.pop_front());
    end
  end

  task automatic checkBit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkVec(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit mRec;
      bit isWr;
      string tag;
      mRec = (mRecLeft > 0);
      isWr = cmdSel && cmdWe;
      checkBit("R2,R6,R11", "sleeping", sleeping, mSleep);
      checkBit("R6,R10", "recovering", recovering, mRec);
      if (mSleep) begin
        checkBit("R3", "memSel", memSel, 1'b0);
        checkBit("R3", "memWe", memWe, 1'b0);
        checkBit("R3", "wrBlockErr", wrBlockErr, 1'b0);
        checkBit("R4", "dataOe", dataOe, 1'b0);
        checkVec("R4", "dataOut", DATA_W'(dataOut), '0);
        checkVec("R5", "memAddr", DATA_W'(memAddr), DATA_W'(mHold));
      end else begin
        tag = mRec ? (isWr ? "R8" : "R7") : "R9";
        checkBit(tag, "memSel", memSel, cmdSel && !(mRec && isWr));
        checkBit(tag, "memWe", memWe, isWr && !mRec);
        checkBit(tag, "wrBlockErr", wrBlockErr, mRec && isWr);
        checkBit(tag, "dataOe", dataOe, oeIn);
        checkVec(tag, "dataOut", dataOut, oeIn ? rdDataIn : '0);
        checkVec("R5", "memAddr", DATA_W'(memAddr), DATA_W'(addrIn));
      end
    end
  end

  task automatic run(bit req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      sleepReq = req;
      cmdSel   = ($urandom_range(0, 3) != 0);
      cmdWe    = ($urandom_range(0, 99) < writeMix);
      addrIn   = ADDR_W'($urandom);
      oeIn     = $urandom_range(0, 1);
      rdDataIn = $urandom;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkBit("R1", "sleeping after reset", sleeping, 1'b0);
    checkBit("R1", "recovering after reset", recovering, 1'b0);
    run(0, 30);                       // R9 normal traffic
    for (int k = 0; k < 6; k++) begin
      run(1, 8 + k);                  // R2..R5 long sleep
      run(0, REC_CYCLES + 6);         // R6..R8 recovery then normal
    end
    writeMix = 90;
    for (int k = 0; k < 4; k++) begin
      run(1, 1);                      // R11 single-cycle pulse
      run(0, REC_CYCLES + 3);
    end
    for (int k = 0; k < 4; k++) begin
      run(1, 5);
      run(0, 1 + k);                  // R10 re-request inside recovery
      run(1, 4);
      run(0, REC_CYCLES + 4);
    end
    writeMix = 50;
    run(0, 40);
    finishRun();
  end
endmodule